// File: doc/BRIEF.md
# Two-Stage Lottery Switch Arbiter

This block arbitrates for a five-port virtual-channel router. Every cycle it looks at the flits waiting at the head of each virtual channel (VC). In the first stage each input port holds a weighted lottery among its own eligible VCs. In the second stage each output port holds a second lottery among the input-port winners that are headed for it. Each requester carries a ticket count, so over many draws its share of wins follows its weight. No requester can be starved for good while it holds tickets.

A mode input selects what is being allocated. In packet mode only header flits take part, and the lottery hands out downstream virtual channels once per packet. In flit mode only body and tail flits take part, and only on VCs that already own a registered channel; the lottery then hands out crossbar slots once per flit. Routing is done upstream: each VC presents the output port it needs. The result is registered. It gives each input port its winning VC index and each output port a one-hot select of the input that drives it.

Top module: `lottery_switch_arb`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every grant output is zero.
- R2: The random source is a 16-bit register S. Reset loads it with 16'hACE1. It shifts left on every clock edge out of reset, whether or not anything requests, and the bit shifted into bit 0 is S[15]^S[13]^S[12]^S[10].
- R3: First stage, per input port: T is the sum of the tickets of its eligible VCs, and the draw is S mod T. The winner is the lowest-numbered VC whose inclusive running ticket sum, in ascending VC order, exceeds the draw.
- R4: Second stage, per output port: the candidates are the first-stage winners whose destination equals that port. Each candidate weighs the tickets of its winning VC. The draw is the byte-swapped S, {S[7:0],S[15:8]}, mod their total. The winner is picked by the same running-sum rule in ascending input-port order.
- R5: With flit_mode=0 (packet mode), a VC is eligible only when its request and its header bit are both set.
- R6: With flit_mode=1 (flit mode), a VC is eligible only when its request is set, its header bit is clear and its channel-owned bit is set.
- R7: A VC with zero tickets never wins. When no VC is eligible, or when all eligible tickets sum to zero, that stage issues no grant.
- R8: Grants are registered. Decisions made from the inputs and from S at one clock edge appear after that edge and last one cycle. Bit o*5+p of xbar_sel set means input p drives output o. Each output's 5-bit group is one-hot or zero.
- R9: gnt_ok[p] is set exactly when input p drives some output. gnt_vc[2p+1:2p] then holds that input's winning VC, and otherwise it is zero.
- R10: The stages are separable. An input whose first-stage winner loses the second stage gets no grant in that cycle, even when another of its VCs could have used a free output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flit_mode | input | 1 | 0 = packet (VC) allocation, 1 = flit (switch) allocation |
| flit_req | input | 20 | Per VC (index p*4+v): a flit is waiting |
| flit_hdr | input | 20 | Per VC: the waiting flit is a header |
| vc_owned | input | 20 | Per VC: a channel is already registered to this VC |
| dest | input | 60 | Per VC, 3 bits at (p*4+v)*3: requested output port |
| tix | input | 80 | Per VC, 4 bits at (p*4+v)*4: ticket count |
| gnt_ok | output | 5 | Per input port: granted this cycle |
| gnt_vc | output | 10 | Per input port, 2 bits: winning VC index |
| xbar_sel | output | 25 | Per output o, bits o*5+4..o*5: one-hot input select |

## Verification
The bench runs a behavioural model that keeps its own copy of the pseudo-random sequence. It therefore catches a wrong tap, a missed advance during idle cycles, or an off-by-one cycle in the draw; any of these would send grants to the wrong VCs. Directed phases push all tickets to zero. A design that ignored weights would still grant in that case, and one that divided by a zero total would produce unknown grants. One phase sets up a port whose local winner may lose at the output while its other VC could have been served. A design that retried locally would give that port a grant the model does not expect. Random phases in both modes check that headers never win in flit mode, that unowned VCs stay out of switch allocation, and that body flits never take part in VC allocation.

// File: rtl/lottery_switch_arb.sv
module lottery_switch_arb #(
  parameter int NPORT = 5,
  parameter int NVC   = 4,
  parameter int TW    = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flit_mode,
  input  logic [NPORT*NVC-1:0]          flit_req,
  input  logic [NPORT*NVC-1:0]          flit_hdr,
  input  logic [NPORT*NVC-1:0]          vc_owned,
  input  logic [NPORT*NVC*$clog2(NPORT)-1:0] dest,
  input  logic [NPORT*NVC*TW-1:0]       tix,
  output logic [NPORT-1:0]              gnt_ok,
  output logic [NPORT*$clog2(NVC)-1:0]  gnt_vc,
  output logic [NPORT*NPORT-1:0]        xbar_sel
);
  localparam int VW = $clog2(NVC);
  localparam int PW = $clog2(NPORT);
  localparam int NREQ = NPORT*NVC;
  localparam logic [15:0] SEED = 16'hACE1;

  logic [15:0] lfsr;
  logic [15:0] swp;
  logic [NREQ-1:0] elig;

  assign swp  = {lfsr[7:0], lfsr[15:8]};
  assign elig = flit_mode ? (flit_req & ~flit_hdr & vc_owned) : (flit_req & flit_hdr);

  logic [15:0]   tot1 [NPORT];
  logic [15:0]   run1 [NPORT];
  logic [15:0]   drw1 [NPORT];
  logic          w1_ok  [NPORT];
  logic [VW-1:0] w1_vc  [NPORT];
  logic [TW-1:0] w1_tk  [NPORT];
  logic [PW-1:0] w1_dst [NPORT];

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      tot1[p] = '0;
      for (int v = 0; v < NVC; v++)
        if (elig[p*NVC+v]) tot1[p] = tot1[p] + 16'(tix[(p*NVC+v)*TW +: TW]);
      drw1[p] = (tot1[p] == '0) ? '0 : lfsr % tot1[p];
      run1[p] = '0;
      w1_ok[p] = 1'b0;
      w1_vc[p] = '0;
      w1_tk[p] = '0;
      w1_dst[p] = '0;
      for (int v = 0; v < NVC; v++) begin
        if (elig[p*NVC+v]) begin
          run1[p] = run1[p] + 16'(tix[(p*NVC+v)*TW +: TW]);
          if (!w1_ok[p] && drw1[p] < run1[p]) begin
            w1_ok[p]  = 1'b1;
            w1_vc[p]  = VW'(v);
            w1_tk[p]  = tix[(p*NVC+v)*TW +: TW];
            w1_dst[p] = dest[(p*NVC+v)*PW +: PW];
          end
        end
      end
    end
  end

  logic [15:0]   tot2 [NPORT];
  logic [15:0]   run2 [NPORT];
  logic [15:0]   drw2 [NPORT];
  logic          w2_ok [NPORT];
  logic [PW-1:0] w2_in [NPORT];
  logic [NPORT*NPORT-1:0] xbar_d;
  logic [NPORT-1:0] gnt_d;
  logic [NPORT*VW-1:0] vc_d;

  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      tot2[o] = '0;
      for (int p = 0; p < NPORT; p++)
        if (w1_ok[p] && w1_dst[p] == PW'(o)) tot2[o] = tot2[o] + 16'(w1_tk[p]);
      drw2[o] = (tot2[o] == '0) ? '0 : swp % tot2[o];
      run2[o] = '0;
      w2_ok[o] = 1'b0;
      w2_in[o] = '0;
      for (int p = 0; p < NPORT; p++) begin
        if (w1_ok[p] && w1_dst[p] == PW'(o)) begin
          run2[o] = run2[o] + 16'(w1_tk[p]);
          if (!w2_ok[o] && drw2[o] < run2[o]) begin
            w2_ok[o] = 1'b1;
            w2_in[o] = PW'(p);
          end
        end
      end
    end
    gnt_d = '0;
    vc_d  = '0;
    for (int o = 0; o < NPORT; o++)
      for (int p = 0; p < NPORT; p++) begin
        xbar_d[o*NPORT+p] = w2_ok[o] && (w2_in[o] == PW'(p));
        if (xbar_d[o*NPORT+p]) begin
          gnt_d[p] = 1'b1;
          vc_d[p*VW +: VW] = w1_vc[p];
        end
      end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr     <= SEED;
      gnt_ok   <= '0;
      gnt_vc   <= '0;
      xbar_sel <= '0;
    end else begin
      lfsr     <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      gnt_ok   <= gnt_d;
      gnt_vc   <= vc_d;
      xbar_sel <= xbar_d;
    end
  end

  p_idle_no_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|flit_req) |=> !(|xbar_sel));

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    p_out_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(xbar_sel[o*NPORT +: NPORT]));
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_in
    p_vc_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !gnt_ok[p] |-> gnt_vc[p*VW +: VW] == '0);
    p_gnt_drives_r9: assert property (@(posedge clk) disable iff (!rst_n)
      gnt_ok[p] |-> $countones(xbar_sel & (NPORT*NPORT)'({NPORT{(NPORT)'(1) << p}})) == 1);
    for (genvar v = 0; v < NVC; v++) begin : g_vc
      p_pkt_elig_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_ok[p] && gnt_vc[p*VW +: VW] == VW'(v) && !$past(flit_mode))
          |-> ($past(flit_req[p*NVC+v]) && $past(flit_hdr[p*NVC+v])));
      p_flit_elig_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_ok[p] && gnt_vc[p*VW +: VW] == VW'(v) && $past(flit_mode))
          |-> ($past(vc_owned[p*NVC+v]) && !$past(flit_hdr[p*NVC+v])));
      p_nonzero_tix_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_ok[p] && gnt_vc[p*VW +: VW] == VW'(v)) |-> $past(tix[(p*NVC+v)*TW +: TW]) != '0);
      p_dest_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_ok[p] && gnt_vc[p*VW +: VW] == VW'(v))
          |-> xbar_sel[int'($past(dest[(p*NVC+v)*PW +: PW]))*NPORT + p]);
    end
  end
endmodule

// File: tb/lottery_switch_arb_bench.sv
module lottery_switch_arb_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flit_mode = 1'b0;
  logic [19:0] flit_req = '0, flit_hdr = '0, vc_owned = '0;
  logic [59:0] dest = '0;
  logic [79:0] tix = '0;
  logic [4:0]  gnt_ok;
  logic [9:0]  gnt_vc;
  logic [24:0] xbar_sel;

  int checks = 0;
  int fails = 0;
  int ms;
  string tag = "R1";
  logic [24:0] ex_x;
  logic [4:0]  ex_g;
  logic [9:0]  ex_v;

  always #2.5 clk = ~clk;

  lottery_switch_arb u_lottery_switch_arb (
    .clk(clk), .rst_n(rst_n), .flit_mode(flit_mode), .flit_req(flit_req),
    .flit_hdr(flit_hdr), .vc_owned(vc_owned), .dest(dest), .tix(tix),
    .gnt_ok(gnt_ok), .gnt_vc(gnt_vc), .xbar_sel(xbar_sel));

  function automatic int step_lfsr(int s);
    int b;
    b = ((s >> 15) ^ (s >> 13) ^ (s >> 12) ^ (s >> 10)) & 1;
    return ((s << 1) | b) & 16'hFFFF;
  endfunction

  function automatic bit ok_vc(int i);
    if (flit_mode) return flit_req[i] && !flit_hdr[i] && vc_owned[i];
    return flit_req[i] && flit_hdr[i];
  endfunction

  task automatic predict();
    int win[5];
    int sw, tot, d, t;
    ex_x = '0; ex_g = '0; ex_v = '0;
    for (int p = 0; p < 5; p++) begin
      win[p] = -1;
      tot = 0;
      for (int v = 0; v < 4; v++) if (ok_vc(p*4+v)) tot += int'(tix[(p*4+v)*4 +: 4]);
      if (tot > 0) begin
        d = ms % tot;
        for (int v = 0; v < 4; v++) begin
          if (win[p] < 0 && ok_vc(p*4+v)) begin
            t = int'(tix[(p*4+v)*4 +: 4]);
            if (d < t) win[p] = v; else d -= t;
          end
        end
      end
    end
    sw = ((ms & 255) << 8) | (ms >> 8);
    for (int o = 0; o < 5; o++) begin
      int pick;
      pick = -1;
      tot = 0;
      for (int p = 0; p < 5; p++)
        if (win[p] >= 0 && int'(dest[(p*4+win[p])*3 +: 3]) == o) tot += int'(tix[(p*4+win[p])*4 +: 4]);
      if (tot > 0) begin
        d = sw % tot;
        for (int p = 0; p < 5; p++) begin
          if (pick < 0 && win[p] >= 0 && int'(dest[(p*4+win[p])*3 +: 3]) == o) begin
            t = int'(tix[(p*4+win[p])*4 +: 4]);
            if (d < t) pick = p; else d -= t;
          end
        end
      end
      if (pick >= 0) begin
        ex_x[o*5+pick] = 1'b1;
        ex_g[pick] = 1'b1;
        ex_v[pick*2 +: 2] = 2'(win[pick]);
      end
    end
  endtask

  task automatic compare();
    checks++;
    if (xbar_sel !== ex_x || gnt_ok !== ex_g || gnt_vc !== ex_v) begin
      fails++;
      $display("FAIL %s xbar=%h exp=%h gnt_ok=%b exp=%b gnt_vc=%h exp=%h",
               tag, xbar_sel, ex_x, gnt_ok, ex_g, gnt_vc, ex_v);
    end
  endtask

  task automatic step();
    predict();
    @(posedge clk);
    ms = step_lfsr(ms);
    @(negedge clk);
    compare();
  endtask

  task automatic run(input string t, input int n, input bit fm, input int pct,
                     input int tmax, input int dmax);
    for (int c = 0; c < n; c++) begin
      tag = t;
      flit_mode = fm;
      for (int i = 0; i < 20; i++) begin
        flit_req[i] = ($urandom_range(99, 0) < pct);
        flit_hdr[i] = 1'($urandom_range(1, 0));
        vc_owned[i] = 1'($urandom_range(1, 0));
        dest[i*3 +: 3] = 3'($urandom_range(dmax, 0));
        tix[i*4 +: 4] = 4'($urandom_range(tmax, 0));
      end
      step();
    end
  endtask

  task automatic clear();
    flit_req = '0; flit_hdr = '0; vc_owned = '0; dest = '0; tix = '0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R1";
    ex_x = '0; ex_g = '0; ex_v = '0;
    compare();
    rst_n = 1'b1;
    ms = 16'hACE1;
    clear();
    tag = "R1";
    step();
    for (int c = 0; c < 37; c++) begin tag = "R2"; step(); end
    run("R2", 30, 1'b0, 60, 15, 4);
    run("R5", 60, 1'b0, 70, 15, 4);
    run("R6", 60, 1'b1, 70, 15, 4);
    run("R4", 60, 1'b0, 90, 15, 0);
    run("R7", 20, 1'b1, 90, 0, 4);
    run("R7", 40, 1'b0, 80, 1, 4);
    clear();
    for (int c = 0; c < 5; c++) begin tag = "R8"; step(); end
    clear();
    flit_mode = 1'b0;
    for (int v = 0; v < 4; v++) begin
      flit_req[8+v] = 1'b1; flit_hdr[8+v] = 1'b1;
      dest[(8+v)*3 +: 3] = 3'(v); tix[(8+v)*4 +: 4] = 4'(1 + 4*v);
    end
    for (int c = 0; c < 30; c++) begin tag = "R3"; step(); end
    clear();
    flit_req[0] = 1'b1; flit_hdr[0] = 1'b1; dest[0 +: 3] = 3'd2; tix[0 +: 4] = 4'd1;
    flit_req[4] = 1'b1; flit_hdr[4] = 1'b1; dest[12 +: 3] = 3'd2; tix[16 +: 4] = 4'd15;
    flit_req[5] = 1'b1; flit_hdr[5] = 1'b1; dest[15 +: 3] = 3'd3; tix[20 +: 4] = 4'd15;
    for (int c = 0; c < 40; c++) begin tag = "R10"; step(); end
    clear();
    flit_req[19] = 1'b1; vc_owned[19] = 1'b1; dest[57 +: 3] = 3'd4; tix[76 +: 4] = 4'd3;
    flit_mode = 1'b1;
    for (int c = 0; c < 10; c++) begin tag = "R6"; step(); end
    flit_mode = 1'b0;
    for (int c = 0; c < 10; c++) begin tag = "R5"; step(); end
    run("R9", 80, 1'b1, 85, 15, 4);
    run("R8", 40, 1'b0, 30, 15, 4);
    summary();
    $finish;
  end
endmodule